// File: doc/BRIEF.md
# Snooping Cache Bus Slave

This block sits beside a small fully associative cache and follows a phase-based memory bus on the cache's behalf while some other master owns the bus. Each transaction opens with a phase pulse that carries an opcode and an argument. The argument is a real address made of a page number and a block number. The block looks that address up in its own tags and then picks one of four actions for the rest of the transaction. It can feed its two cached words onto the bus, take two words from the bus into the line, do both in turn, or just acknowledge a fixed number of phases. Every phase gets a done pulse from the block.

Coherence is kept with per-line flags, which the block also updates. These are virtual-valid, real-valid, line-dirty, shared and page-dirty. When the block owns a copy of the requested block, it raises its contribution to the wired shared line.

The processor side of the cache loads lines through a fill port and reads them back through a probe port. Arbitration, the page map and miss handling on the processor side belong to other blocks.

Top module: `snoop_bus_slave`

## Requirements
- R1: When rst_ni is low, done_o, bus_drive_o and shared_o are low and every line's flags are zero. probe_flags_o bit 0 is virtual-valid, bit 1 real-valid, bit 2 line-dirty, bit 3 shared and bit 4 page-dirty.
- R2: A transaction starts only when new_phase_i and op_valid_i are both high while no transaction is open. The argument is bus_i[RP_W+BLK_W-1:0] = {page, block}. The opcodes are 0 fetch, 1 store, 2 shared-fetch, 3 set-map-dirty, 4 invalidate-virtual, 5 invalidate-real, 6 write-map, 7 read-map and 8 write-map-flags. done_o is high in the cycle after the opcode pulse. While a transaction is open, op_valid_i is ignored and every pulse is a data phase.
- R3: A fetch whose page and block match a line with real-valid set is a fetch hit. shared_o rises in the cycle after the opcode pulse. On the next two pulses the block drives word 0 and then word 1 on bus_data_o, with bus_drive_o high for the two cycles after each pulse and done_o high two cycles after it. The line's shared flag is set at the end.
- R4: A fetch miss drives nothing and leaves shared_o low. It acknowledges two data phases, each with done_o one cycle after the pulse.
- R5: A store hit clears line-dirty at the opcode pulse. It then writes bus_i into word 0 and word 1 on the next two pulses. A store miss only acknowledges two phases.
- R6: Store and shared-fetch set page-dirty on every line whose page equals the argument's page, whether the block hits or misses.
- R7: A shared-fetch hit sets line-dirty and raises shared_o. It drives its two words as in R3 and then writes the next two pulses' bus_i into word 0 and word 1.
- R8: A shared-fetch miss acknowledges two data phases. If shared_i is high at the first data pulse, it acknowledges four.
- R9: Invalidate-virtual clears virtual-valid, and invalidate-real clears real-valid, on every line whose page equals the argument's page. Neither has any data phase.
- R10: Set-map-dirty, write-map-flags and unlisted codes get only the opcode done. Write-map and read-map get one further acknowledged phase.
- R11: exception_i high while a transaction is open closes it at that edge. shared_o drops, no further done_o follows, the line's shared flag stays as it was, and the next opcode pulse is accepted.
- R12: fill_we_i loads page, block, flags and both words into line fill_idx_i at the clock edge. The probe outputs show line probe_idx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| new_phase_i | input | 1 | One-cycle phase pulse |
| op_valid_i | input | 1 | Pulse carries an opcode |
| op_i | input | 4 | Opcode |
| bus_i | input | DATA_W | Argument or data word on the bus |
| exception_i | input | 1 | Exception raised on the bus |
| shared_i | input | 1 | Wired shared line as seen on the bus |
| done_o | output | 1 | Phase acknowledge |
| bus_drive_o | output | 1 | Block is driving bus_data_o |
| bus_data_o | output | DATA_W | Supplied data word |
| shared_o | output | 1 | This block's drive of the shared line |
| fill_we_i | input | 1 | Line load strobe |
| fill_idx_i | input | IDX_W | Line to load |
| fill_rp_i | input | RP_W | Page to load |
| fill_blk_i | input | BLK_W | Block to load |
| fill_flags_i | input | 5 | Flags to load |
| fill_w0_i | input | DATA_W | Word 0 to load |
| fill_w1_i | input | DATA_W | Word 1 to load |
| probe_idx_i | input | IDX_W | Line to read |
| probe_rp_o | output | RP_W | Page of probed line |
| probe_blk_o | output | BLK_W | Block of probed line |
| probe_flags_o | output | 5 | Flags of probed line |
| probe_w0_o | output | DATA_W | Word 0 of probed line |
| probe_w1_o | output | DATA_W | Word 1 of probed line |

## Verification
The opcode done, the done of each sampled or acknowledged phase, flag updates and word captures all come one clock after the pulse. A supplied word appears on bus_data_o in that same cycle, and its done comes one clock later. Each scenario task raises a phase on a falling edge and samples the outputs on the next falling edge and the one after. It reads the line state through the probe port straight after the pulse that should have changed it. The phase count of each transaction is checked at its end by issuing a fetch that hits. That fetch is a fresh transaction only if it raises shared_o.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int FLAG_W = 5;
  localparam int FL_VA  = 0;
  localparam int FL_RA  = 1;
  localparam int FL_CE  = 2;
  localparam int FL_SH  = 3;
  localparam int FL_RPD = 4;

  typedef enum logic [3:0] {
    OP_FETCH          = 4'd0,
    OP_STORE          = 4'd1,
    OP_SFETCH         = 4'd2,
    OP_SET_MAP_DIRTY  = 4'd3,
    OP_INV_VP         = 4'd4,
    OP_INV_RP         = 4'd5,
    OP_WRITE_MAP      = 4'd6,
    OP_READ_MAP       = 4'd7,
    OP_WRITE_MAP_FLGS = 4'd8
  } bus_op_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_FETCH_HIT,
    K_STORE_HIT,
    K_SFETCH_HIT,
    K_SKIP,
    K_SFETCH_MISS
  } kind_e;

endpackage

// File: rtl/snoop_tag_match.sv
module snoop_tag_match #(
  parameter int LINES = 4,
  parameter int RP_W  = 8,
  parameter int BLK_W = 4,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic [RP_W-1:0]  q_rp_i,
  input  logic [BLK_W-1:0] q_blk_i,
  input  logic [RP_W-1:0]  rp_i  [LINES],
  input  logic [BLK_W-1:0] blk_i [LINES],
  input  logic [LINES-1:0] ra_valid_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [LINES-1:0] rp_eq_o
);

  logic [LINES-1:0] blk_hit;

  for (genvar l = 0; l < LINES; l++) begin : g_cmp
    assign rp_eq_o[l] = (rp_i[l] == q_rp_i);
    assign blk_hit[l] = rp_eq_o[l] && (blk_i[l] == q_blk_i) && ra_valid_i[l];
  end

  // lowest index wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (blk_hit[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end

  // R4
  always_comb begin
    hit_rp_chk: assert (!hit_o || (rp_eq_o[hit_idx_o] && ra_valid_i[hit_idx_o]));
  end

endmodule

// File: rtl/snoop_line_store.sv
module snoop_line_store
  import snoop_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int RP_W   = 8,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [RP_W-1:0]   fill_rp_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic [FLAG_W-1:0] fill_flags_i,
  input  logic [DATA_W-1:0] fill_w0_i,
  input  logic [DATA_W-1:0] fill_w1_i,
  input  logic [LINES-1:0]  rpd_set_i,
  input  logic [LINES-1:0]  va_clr_i,
  input  logic [LINES-1:0]  ra_clr_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              ce_set_i,
  input  logic              ce_clr_i,
  input  logic              sh_set_i,
  input  logic              wr_en_i,
  input  logic              wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [RP_W-1:0]   rp_o    [LINES],
  output logic [BLK_W-1:0]  blk_o   [LINES],
  output logic [FLAG_W-1:0] flags_o [LINES],
  output logic [DATA_W-1:0] w0_o    [LINES],
  output logic [DATA_W-1:0] w1_o    [LINES]
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [RP_W-1:0]   rp_q;
    logic [BLK_W-1:0]  blk_q;
    logic [FLAG_W-1:0] fl_q, fl_n;
    logic [DATA_W-1:0] w0_q, w1_q;
    logic              sel, fill_sel;

    assign sel      = (upd_idx_i == IDX_W'(l));
    assign fill_sel = fill_we_i && (fill_idx_i == IDX_W'(l));

    always_comb begin
      fl_n = fl_q;
      if (rpd_set_i[l])       fl_n[FL_RPD] = 1'b1;
      if (va_clr_i[l])        fl_n[FL_VA]  = 1'b0;
      if (ra_clr_i[l])        fl_n[FL_RA]  = 1'b0;
      if (sel && ce_set_i)    fl_n[FL_CE]  = 1'b1;
      if (sel && ce_clr_i)    fl_n[FL_CE]  = 1'b0;
      if (sel && sh_set_i)    fl_n[FL_SH]  = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rp_q  <= '0;
        blk_q <= '0;
        fl_q  <= '0;
        w0_q  <= '0;
        w1_q  <= '0;
      end else if (fill_sel) begin
        rp_q  <= fill_rp_i;
        blk_q <= fill_blk_i;
        fl_q  <= fill_flags_i;
        w0_q  <= fill_w0_i;
        w1_q  <= fill_w1_i;
      end else begin
        fl_q <= fl_n;
        if (sel && wr_en_i && !wr_word_i) w0_q <= wr_data_i;
        if (sel && wr_en_i &&  wr_word_i) w1_q <= wr_data_i;
      end
    end

    assign rp_o[l]    = rp_q;
    assign blk_o[l]   = blk_q;
    assign flags_o[l] = fl_q;
    assign w0_o[l]    = w0_q;
    assign w1_o[l]    = w1_q;

    // R9
    va_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (va_clr_i[l] && !fill_sel) |=> !fl_q[FL_VA]);
  end

endmodule

// File: rtl/snoop_phase_ctl.sv
module snoop_phase_ctl
  import snoop_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_phase_i,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              exc_i,
  input  logic              shared_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [LINES-1:0]  rp_eq_i,
  input  logic [DATA_W-1:0] line_w0_i,
  input  logic [DATA_W-1:0] line_w1_i,
  output logic [IDX_W-1:0]  loc_o,
  output logic [LINES-1:0]  rpd_set_o,
  output logic [LINES-1:0]  va_clr_o,
  output logic [LINES-1:0]  ra_clr_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic              ce_set_o,
  output logic              ce_clr_o,
  output logic              sh_set_o,
  output logic              wr_en_o,
  output logic              wr_word_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              drive_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              shared_o
);

  kind_e             kind_q, kind_n;
  logic [2:0]        left_q, left_n, left_dec;
  logic [1:0]        pidx_q;
  logic [IDX_W-1:0]  loc_q;
  logic              busy_q, done_q, drv_pend_q, drive_q, shared_q;
  logic [DATA_W-1:0] dout_q;
  logic              start, dphase, abort, drive_ph, cap_ph, extend, last;

  // per-opcode plan
  always_comb begin
    kind_n = K_NONE;
    left_n = 3'd0;
    case (op_i)
      OP_FETCH:     begin kind_n = hit_i ? K_FETCH_HIT  : K_SKIP;        left_n = 3'd2; end
      OP_STORE:     begin kind_n = hit_i ? K_STORE_HIT  : K_SKIP;        left_n = 3'd2; end
      OP_SFETCH:    begin kind_n = hit_i ? K_SFETCH_HIT : K_SFETCH_MISS; left_n = hit_i ? 3'd4 : 3'd2; end
      OP_WRITE_MAP,
      OP_READ_MAP:  begin kind_n = K_SKIP; left_n = 3'd1; end
      default: ;
    endcase
  end

  assign start    = new_phase_i && op_valid_i && !busy_q && !exc_i;
  assign dphase   = new_phase_i && busy_q && !exc_i;
  assign abort    = busy_q && exc_i;
  assign drive_ph = dphase && ((kind_q == K_FETCH_HIT) || ((kind_q == K_SFETCH_HIT) && !pidx_q[1]));
  assign cap_ph   = dphase && ((kind_q == K_STORE_HIT) || ((kind_q == K_SFETCH_HIT) && pidx_q[1]));
  assign extend   = dphase && (kind_q == K_SFETCH_MISS) && (pidx_q == 2'd0) && shared_i;
  assign left_dec = extend ? left_q + 3'd1 : left_q - 3'd1;
  assign last     = dphase && (left_dec == 3'd0);

  // flag and data updates, applied at the pulse edge
  assign rpd_set_o = (start && (op_i == OP_STORE || op_i == OP_SFETCH)) ? rp_eq_i : '0;
  assign va_clr_o  = (start && op_i == OP_INV_VP) ? rp_eq_i : '0;
  assign ra_clr_o  = (start && op_i == OP_INV_RP) ? rp_eq_i : '0;
  assign upd_idx_o = start ? hit_idx_i : loc_q;
  assign ce_set_o  = start && hit_i && (op_i == OP_SFETCH);
  assign ce_clr_o  = start && hit_i && (op_i == OP_STORE);
  assign sh_set_o  = last && (kind_q == K_FETCH_HIT);
  assign wr_en_o   = cap_ph;
  assign wr_word_o = pidx_q[0];
  assign wr_data_o = bus_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q     <= K_NONE;
      left_q     <= '0;
      pidx_q     <= '0;
      loc_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      drv_pend_q <= 1'b0;
      drive_q    <= 1'b0;
      shared_q   <= 1'b0;
      dout_q     <= '0;
    end else begin
      done_q     <= start || (dphase && !drive_ph) || drv_pend_q;
      drv_pend_q <= drive_ph;
      drive_q    <= drive_ph || drv_pend_q;
      if (drive_ph) dout_q <= pidx_q[0] ? line_w1_i : line_w0_i;
      if (start) begin
        busy_q   <= (left_n != 3'd0);
        kind_q   <= kind_n;
        left_q   <= left_n;
        pidx_q   <= '0;
        loc_q    <= hit_idx_i;
        shared_q <= hit_i && (op_i == OP_FETCH || op_i == OP_SFETCH);
      end else if (abort) begin
        busy_q   <= 1'b0;
        shared_q <= 1'b0;
        left_q   <= '0;
        kind_q   <= K_NONE;
      end else if (dphase) begin
        left_q <= left_dec;
        pidx_q <= pidx_q + 2'd1;
        if (last) begin
          busy_q   <= 1'b0;
          shared_q <= 1'b0;
          kind_q   <= K_NONE;
        end
      end
    end
  end

  assign loc_o    = loc_q;
  assign done_o   = done_q;
  assign drive_o  = drive_q;
  assign dout_o   = dout_q;
  assign shared_o = shared_q;

  // R3
  drive_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |=> (done_q && drive_q));

  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && exc_i) |=> (!shared_q && !busy_q));

  // R7
  shared_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_q |-> busy_q);

  // R8
  left_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != 3'd0 && left_q <= 3'd4));

endmodule

// File: rtl/snoop_bus_slave.sv
module snoop_bus_slave
  import snoop_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int RP_W   = 8,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = RP_W + BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_phase_i,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              exception_i,
  input  logic              shared_i,
  output logic              done_o,
  output logic              bus_drive_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              shared_o,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [RP_W-1:0]   fill_rp_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic [4:0]        fill_flags_i,
  input  logic [DATA_W-1:0] fill_w0_i,
  input  logic [DATA_W-1:0] fill_w1_i,
  input  logic [IDX_W-1:0]  probe_idx_i,
  output logic [RP_W-1:0]   probe_rp_o,
  output logic [BLK_W-1:0]  probe_blk_o,
  output logic [4:0]        probe_flags_o,
  output logic [DATA_W-1:0] probe_w0_o,
  output logic [DATA_W-1:0] probe_w1_o
);

  logic [RP_W-1:0]   rp_w    [LINES];
  logic [BLK_W-1:0]  blk_w   [LINES];
  logic [FLAG_W-1:0] flags_w [LINES];
  logic [DATA_W-1:0] w0_w    [LINES];
  logic [DATA_W-1:0] w1_w    [LINES];
  logic [LINES-1:0]  ra_valid, rp_eq, rpd_set, va_clr, ra_clr;
  logic              hit, ce_set, ce_clr, sh_set, wr_en, wr_word, drive;
  logic [IDX_W-1:0]  hit_idx, loc, upd_idx;
  logic [DATA_W-1:0] wr_data, dout;

  for (genvar l = 0; l < LINES; l++) begin : g_rav
    assign ra_valid[l] = flags_w[l][FL_RA];
  end

  snoop_tag_match #(.LINES(LINES), .RP_W(RP_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_match (
    .q_rp_i     (bus_i[ADDR_W-1:BLK_W]),
    .q_blk_i    (bus_i[BLK_W-1:0]),
    .rp_i       (rp_w),
    .blk_i      (blk_w),
    .ra_valid_i (ra_valid),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .rp_eq_o    (rp_eq)
  );

  snoop_phase_ctl #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .new_phase_i(new_phase_i),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .bus_i      (bus_i),
    .exc_i      (exception_i),
    .shared_i   (shared_i),
    .hit_i      (hit),
    .hit_idx_i  (hit_idx),
    .rp_eq_i    (rp_eq),
    .line_w0_i  (w0_w[loc]),
    .line_w1_i  (w1_w[loc]),
    .loc_o      (loc),
    .rpd_set_o  (rpd_set),
    .va_clr_o   (va_clr),
    .ra_clr_o   (ra_clr),
    .upd_idx_o  (upd_idx),
    .ce_set_o   (ce_set),
    .ce_clr_o   (ce_clr),
    .sh_set_o   (sh_set),
    .wr_en_o    (wr_en),
    .wr_word_o  (wr_word),
    .wr_data_o  (wr_data),
    .done_o     (done_o),
    .drive_o    (drive),
    .dout_o     (dout),
    .shared_o   (shared_o)
  );

  snoop_line_store #(.LINES(LINES), .RP_W(RP_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_we_i   (fill_we_i),
    .fill_idx_i  (fill_idx_i),
    .fill_rp_i   (fill_rp_i),
    .fill_blk_i  (fill_blk_i),
    .fill_flags_i(fill_flags_i),
    .fill_w0_i   (fill_w0_i),
    .fill_w1_i   (fill_w1_i),
    .rpd_set_i   (rpd_set),
    .va_clr_i    (va_clr),
    .ra_clr_i    (ra_clr),
    .upd_idx_i   (upd_idx),
    .ce_set_i    (ce_set),
    .ce_clr_i    (ce_clr),
    .sh_set_i    (sh_set),
    .wr_en_i     (wr_en),
    .wr_word_i   (wr_word),
    .wr_data_i   (wr_data),
    .rp_o        (rp_w),
    .blk_o       (blk_w),
    .flags_o     (flags_w),
    .w0_o        (w0_w),
    .w1_o        (w1_w)
  );

  assign bus_drive_o   = drive;
  assign bus_data_o    = drive ? dout : '0;
  assign probe_rp_o    = rp_w[probe_idx_i];
  assign probe_blk_o   = blk_w[probe_idx_i];
  assign probe_flags_o = flags_w[probe_idx_i];
  assign probe_w0_o    = w0_w[probe_idx_i];
  assign probe_w1_o    = w1_w[probe_idx_i];

  // R5
  cap_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !bus_drive_o || $past(bus_drive_o));

endmodule

// File: tb/sim_snoop_bus_slave.sv
module sim_snoop_bus_slave;
  import snoop_pkg::*;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          new_phase = 0, op_valid = 0, exc = 0, sh_other = 0;
  logic [3:0]    op = 0;
  logic [DW-1:0] bus = 0;
  logic          shared_line, done, drv, shared_o;
  logic [DW-1:0] bus_q;
  logic          fill_we = 0;
  logic [1:0]    fill_idx = 0, probe_idx = 0;
  logic [7:0]    fill_rp = 0, probe_rp;
  logic [3:0]    fill_blk = 0, probe_blk;
  logic [4:0]    fill_flags = 0, probe_flags;
  logic [DW-1:0] fill_w0 = 0, fill_w1 = 0, probe_w0, probe_w1;

  assign shared_line = sh_other | shared_o;

  snoop_bus_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .new_phase_i(new_phase), .op_valid_i(op_valid),
    .op_i(op), .bus_i(bus), .exception_i(exc), .shared_i(shared_line),
    .done_o(done), .bus_drive_o(drv), .bus_data_o(bus_q), .shared_o(shared_o),
    .fill_we_i(fill_we), .fill_idx_i(fill_idx), .fill_rp_i(fill_rp), .fill_blk_i(fill_blk),
    .fill_flags_i(fill_flags), .fill_w0_i(fill_w0), .fill_w1_i(fill_w1),
    .probe_idx_i(probe_idx), .probe_rp_o(probe_rp), .probe_blk_o(probe_blk),
    .probe_flags_o(probe_flags), .probe_w0_o(probe_w0), .probe_w1_o(probe_w1)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ad(input logic [7:0] rp, input logic [3:0] blk);
    return {20'h0, rp, blk};
  endfunction

  logic dn1, dn2, dv1, sh1;
  logic [DW-1:0] q1;

  // one phase: pulse, sample one and two cycles later, one idle cycle
  task automatic phase(input logic opv, input logic [3:0] o, input logic [DW-1:0] b);
    new_phase = 1; op_valid = opv; op = o; bus = b;
    @(negedge clk);
    new_phase = 0; op_valid = 0;
    dn1 = done; dv1 = drv; q1 = bus_q; sh1 = shared_o;
    @(negedge clk);
    dn2 = done;
    @(negedge clk);
  endtask

  task automatic ack_phase(input string req);
    phase(0, 4'd0, 32'h0);
    check({req, " ack done"}, {dn1, dn2, dv1}, 3'b100);
  endtask

  task automatic probe(input logic [1:0] i);
    probe_idx = i;
    #1;
  endtask

  task automatic pulse_exc();
    exc = 1;
    @(negedge clk);
    exc = 0;
    check("R11 shared drop", shared_o, 1'b0);
    @(negedge clk);
    check("R11 no done", done, 1'b0);
  endtask

  // a fetch hit on line 3 is a new transaction only if shared_o rises
  task automatic expect_idle(input string req);
    phase(1, OP_FETCH, ad(8'h56, 4'h1));
    check({req, " next op accepted"}, sh1, 1'b1);
    pulse_exc();
  endtask

  task automatic fill(input logic [1:0] i, input logic [7:0] rp, input logic [3:0] blk,
                      input logic [4:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b);
    fill_we = 1; fill_idx = i; fill_rp = rp; fill_blk = blk; fill_flags = f; fill_w0 = a; fill_w1 = b;
    @(negedge clk);
    fill_we = 0;
  endtask

  task automatic t_reset();
    check("R1 done", done, 1'b0);
    check("R1 drive", drv, 1'b0);
    check("R1 shared", shared_o, 1'b0);
    probe(2'd0);
    check("R1 flags", probe_flags, 5'b0);
  endtask

  task automatic t_fill();
    fill(2'd0, 8'h12, 4'h3, 5'b00011, 32'hA0A0_0000, 32'hA0A0_0001);
    fill(2'd1, 8'h12, 4'h5, 5'b00111, 32'hB0B0_0000, 32'hB0B0_0001);
    fill(2'd2, 8'h34, 4'h3, 5'b00001, 32'hC0C0_0000, 32'hC0C0_0001);
    fill(2'd3, 8'h56, 4'h1, 5'b00011, 32'hD0D0_0000, 32'hD0D0_0001);
    probe(2'd1);
    check("R12 probe rp/blk", {probe_rp, probe_blk}, {8'h12, 4'h5});
    check("R12 probe words", {probe_w0, probe_w1}, {32'hB0B0_0000, 32'hB0B0_0001});
  endtask

  task automatic t_fetch_hit();
    phase(1, OP_FETCH, ad(8'h12, 4'h3));
    check("R2 opcode done", {dn1, dn2}, 2'b10);
    check("R3 shared raised", sh1, 1'b1);
    phase(0, 4'd0, 32'h0);
    check("R3 word0", q1, 32'hA0A0_0000);
    check("R3 drive/done timing", {dv1, dn1, dn2}, 3'b101);
    phase(0, 4'd0, 32'h0);
    check("R3 word1", q1, 32'hA0A0_0001);
    check("R3 drive/done timing 2", {dv1, dn1, dn2}, 3'b101);
    check("R3 shared released", shared_o, 1'b0);
    probe(2'd0);
    check("R3 line shared flag", probe_flags, 5'b01011);
  endtask

  task automatic t_fetch_miss();
    phase(1, OP_FETCH, ad(8'h34, 4'h3));
    check("R4 no shared", {sh1, dn1}, 2'b01);
    ack_phase("R4");
    ack_phase("R4");
    expect_idle("R4");
  endtask

  task automatic t_store();
    phase(1, OP_STORE, ad(8'h12, 4'h5));
    probe(2'd1);
    check("R5 dirty cleared, R6 page dirty", probe_flags, 5'b10011);
    probe(2'd0);
    check("R6 other line same page", probe_flags, 5'b11011);
    probe(2'd2);
    check("R6 other page untouched", probe_flags, 5'b00001);
    phase(0, 4'd0, 32'hE0E0_0000);
    check("R5 capture done", {dv1, dn1, dn2}, 3'b010);
    phase(0, 4'd0, 32'hE0E0_0001);
    probe(2'd1);
    check("R5 words captured", {probe_w0, probe_w1}, {32'hE0E0_0000, 32'hE0E0_0001});
    expect_idle("R5");
    phase(1, OP_STORE, ad(8'h56, 4'h7));
    probe(2'd3);
    check("R6 miss sets page dirty", probe_flags, 5'b10011);
    phase(0, 4'd0, 32'h1111_1111);
    phase(0, 4'd0, 32'h2222_2222);
    probe(2'd3);
    check("R5 miss leaves data", {probe_w0, probe_w1}, {32'hD0D0_0000, 32'hD0D0_0001});
    expect_idle("R5");
  endtask

  task automatic t_sfetch_hit();
    phase(1, OP_SFETCH, ad(8'h56, 4'h1));
    check("R7 shared", sh1, 1'b1);
    probe(2'd3);
    check("R7 line dirty set", probe_flags, 5'b10111);
    phase(0, 4'd0, 32'h0);
    check("R7 drive word0", {dv1, q1}, {1'b1, 32'hD0D0_0000});
    phase(0, 4'd0, 32'h0);
    check("R7 drive word1", {dv1, q1}, {1'b1, 32'hD0D0_0001});
    phase(0, 4'd0, 32'hF0F0_0000);
    check("R7 capture done", {dv1, dn1}, 2'b01);
    phase(0, 4'd0, 32'hF0F0_0001);
    probe(2'd3);
    check("R7 words captured", {probe_w0, probe_w1}, {32'hF0F0_0000, 32'hF0F0_0001});
    check("R7 shared released", shared_o, 1'b0);
    expect_idle("R7");
  endtask

  task automatic t_sfetch_miss();
    phase(1, OP_SFETCH, ad(8'h34, 4'h9));
    probe(2'd2);
    check("R6 sfetch miss page dirty", probe_flags, 5'b10001);
    ack_phase("R8");
    ack_phase("R8");
    expect_idle("R8 two phases");
    phase(1, OP_SFETCH, ad(8'h34, 4'h9));
    sh_other = 1;
    ack_phase("R8");
    sh_other = 0;
    ack_phase("R8");
    phase(1, OP_FETCH, ad(8'h56, 4'h1));
    check("R2 op ignored while open", {sh1, dn1}, 2'b01);
    ack_phase("R8");
    expect_idle("R8 four phases");
  endtask

  task automatic t_invalidate();
    phase(1, OP_INV_VP, ad(8'h12, 4'h0));
    check("R9 done", dn1, 1'b1);
    probe(2'd0);
    check("R9 va cleared l0", probe_flags, 5'b11010);
    probe(2'd1);
    check("R9 va cleared l1", probe_flags, 5'b10010);
    expect_idle("R9 inv-va");
    phase(1, OP_INV_RP, ad(8'h12, 4'h0));
    probe(2'd0);
    check("R9 ra cleared l0", probe_flags, 5'b11000);
    probe(2'd3);
    check("R9 other page kept", probe_flags, 5'b10111);
    expect_idle("R9 inv-ra");
    phase(1, OP_FETCH, ad(8'h12, 4'h3));
    check("R9 fetch now misses", sh1, 1'b0);
    ack_phase("R9");
    ack_phase("R9");
  endtask

  task automatic t_map_ops();
    phase(1, OP_SET_MAP_DIRTY, ad(8'h12, 4'h0));
    check("R10 set-map-dirty done", {dn1, dn2}, 2'b10);
    expect_idle("R10 set-map-dirty");
    phase(1, OP_WRITE_MAP_FLGS, 32'h0);
    expect_idle("R10 write-map-flags");
    phase(1, 4'd15, 32'h0);
    check("R10 unlisted done", dn1, 1'b1);
    expect_idle("R10 unlisted");
    phase(1, OP_WRITE_MAP, 32'h0);
    ack_phase("R10 write-map");
    expect_idle("R10 write-map");
    phase(1, OP_READ_MAP, 32'h0);
    pulse_exc();
    expect_idle("R11 read-map exception");
  endtask

  task automatic t_abort();
    phase(1, OP_FETCH, ad(8'h56, 4'h1));
    phase(0, 4'd0, 32'h0);
    check("R11 first word", q1, 32'hF0F0_0000);
    pulse_exc();
    probe(2'd3);
    check("R11 shared flag untouched", probe_flags, 5'b10111);
    expect_idle("R11");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_fill();
    t_fetch_hit();
    t_fetch_miss();
    t_store();
    t_sfetch_hit();
    t_sfetch_miss();
    t_invalidate();
    t_map_ops();
    t_abort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule